// File: doc/BRIEF.md
# Integer Arithmetic Execute Unit

This combinational unit is the arithmetic part of the execute stage of a 32-bit integer pipeline. The decode stage supplies an operation select, two operands and a destination register address. The second operand is either a register value or an immediate that decode has already sign-extended. Decode also supplies a request to write the destination. In the same cycle the unit returns the result, the destination address and the final write enable. For the widening multiplies it returns a high word and a low word, each with its own write strobe.

The unit covers the following operations:
- add and subtract, each in a trapping-style form and a wrapping form;
- register and immediate compares, each signed or unsigned;
- a count of the leading zero bits and a count of the leading one bits;
- a multiply that keeps only the low word;
- a signed multiply and an unsigned multiply, each producing a double-width product.

The unit never traps. When a checked add or subtract overflows, it drops the register write.

The operation select is 5 bits wide. The codes are 0 none, 1 ADD, 2 ADDU, 3 SUB, 4 SUBU, 5 SLT, 6 SLTU, 7 CLZ, 8 CLO, 9 MUL, 10 MULT, 11 MULTU, 12 ADDI, 13 ADDIU, 14 SLTI and 15 SLTIU. Codes 16 to 31 are unrecognised.

Top module: `mia_arith_unit`

## Requirements
- R1: For ADD(1), ADDU(2), ADDI(12) and ADDIU(13), `result` equals `opa + opb` modulo 2^32. For SUB(3) and SUBU(4), `result` equals `opa - opb` modulo 2^32. This holds whether or not the operation overflows.
- R2: For ADD(1), ADDI(12) and SUB(3), a signed overflow forces `wb_en` to 0. Signed overflow means the true signed result lies outside [-2^31, 2^31-1]; for SUB this includes `opb` = 0x80000000. Without overflow, `wb_en` equals `wb_req`. For example, ADD of 0x80000001 and 0x80000002 gives `wb_en` = 0.
- R3: ADDU(2), SUBU(4) and ADDIU(13) never check overflow, and `wb_en` equals `wb_req`. For example, ADDU of 0x80000001 and 0x80000002 gives 0x00000003.
- R4: SLT(5) and SLTI(14) compare as signed; SLTU(6) and SLTIU(15) compare as unsigned. Each writes `result` = 1 when `opa` < `opb` and 0 otherwise, with `wb_en` equal to `wb_req`.
- R5: CLZ(7) returns in `result` the number of consecutive 0 bits of `opa`, counted from bit 31 downward. An all-zero `opa` gives 32.
- R6: CLO(8) returns in `result` the number of consecutive 1 bits of `opa`, counted from bit 31 downward. An all-ones `opa` gives 32.
- R7: MUL(9) returns the low 32 bits of the product in `result`, with `wb_en` equal to `wb_req`. Both `hi_we` and `lo_we` are 0.
- R8: MULT(10) puts the signed 64-bit product of `opa` and `opb` in `hi_val` (upper word) and `lo_val` (lower word). It drives `hi_we` = `lo_we` = 1, `wb_en` = 0 and `result` = 0.
- R9: MULTU(11) behaves as R8 but with an unsigned product.
- R10: For every recognised code, `dst_out` equals `dst_in`. For every code other than 10 and 11, `hi_we`, `lo_we`, `hi_val` and `lo_val` are all 0.
- R11: For code 0 and for codes 16 to 31, `wb_en`, `dst_out`, `result`, `hi_val`, `lo_val`, `hi_we` and `lo_we` are all 0.
- R12: When `wb_req` is 0, `wb_en` is 0 for every code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 5 | Decoded operation code |
| opa | input | 32 | First operand (register value) |
| opb | input | 32 | Second operand (register value or sign-extended immediate) |
| dst_in | input | 5 | Destination register address from decode |
| wb_req | input | 1 | Decode requests a register write |
| wb_en | output | 1 | Final register write enable |
| dst_out | output | 5 | Destination register address to write-back |
| result | output | 32 | Value for the general register |
| hi_val | output | 32 | Upper product word |
| lo_val | output | 32 | Lower product word |
| hi_we | output | 1 | High word write strobe |
| lo_we | output | 1 | Low word write strobe |

## Verification
The assertions assume that the inputs settle within a cycle. They also assume that an immediate form arrives with `opb` already sign-extended, so the properties for the register and immediate forms are identical. The stimulus changes inputs only just after a rising edge and samples on the falling edge. It draws immediate operands as sign-extended 16-bit values, and it also issues codes 16 to 31 so that the unrecognised path is covered. Operand draws are biased toward the sign boundary, toward all-ones and toward shifted runs of bits, so that overflow and leading-count corners occur often.

// File: rtl/mia_pkg.sv
// Package: operation codes and widths shared by the arithmetic unit,
// its checker and its bench. Assumes a 5-bit operation select.
package mia_pkg;
    localparam int OP_W = 5;

    localparam logic [OP_W-1:0] OPC_NONE  = 5'd0;
    localparam logic [OP_W-1:0] OPC_ADD   = 5'd1;
    localparam logic [OP_W-1:0] OPC_ADDU  = 5'd2;
    localparam logic [OP_W-1:0] OPC_SUB   = 5'd3;
    localparam logic [OP_W-1:0] OPC_SUBU  = 5'd4;
    localparam logic [OP_W-1:0] OPC_SLT   = 5'd5;
    localparam logic [OP_W-1:0] OPC_SLTU  = 5'd6;
    localparam logic [OP_W-1:0] OPC_CLZ   = 5'd7;
    localparam logic [OP_W-1:0] OPC_CLO   = 5'd8;
    localparam logic [OP_W-1:0] OPC_MUL   = 5'd9;
    localparam logic [OP_W-1:0] OPC_MULT  = 5'd10;
    localparam logic [OP_W-1:0] OPC_MULTU = 5'd11;
    localparam logic [OP_W-1:0] OPC_ADDI  = 5'd12;
    localparam logic [OP_W-1:0] OPC_ADDIU = 5'd13;
    localparam logic [OP_W-1:0] OPC_SLTI  = 5'd14;
    localparam logic [OP_W-1:0] OPC_SLTIU = 5'd15;
endpackage

// File: rtl/mia_addsub.sv
// Module: shared adder for add and subtract. Subtract adds the inverted
// second operand plus one. Flags two's-complement overflow of the true
// signed result. Purely combinational.
module mia_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         ovf
);
    localparam int MSB = W - 1;

    logic [W-1:0] b_eff;

    // Select the true or inverted second operand and add.
    always_comb begin
        b_eff = sub ? ~b : b;
        sum   = a + b_eff + W'(sub);
    end

    // Overflow: the operand signs allow it and the result sign flipped.
    always_comb begin
        if (sub) ovf = (a[MSB] != b[MSB]) && (sum[MSB] != a[MSB]);
        else     ovf = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
    end
endmodule

// File: rtl/mia_lead_count.sv
// Module: counts the run of bits equal to the chosen polarity, starting
// at the most significant bit. Returns W when every bit matches.
// Purely combinational.
module mia_lead_count #(
    parameter int W  = 32,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  val,
    input  logic          count_ones,
    output logic [CW-1:0] count
);
    logic [W-1:0] probe;

    // Reduce both counts to a leading-zero count.
    always_comb probe = count_ones ? ~val : val;

    // The highest set bit of the probe ends the run.
    always_comb begin
        count = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (probe[i]) count = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/mia_mult.sv
// Module: double-width multiplier. It extends both operands to 2W bits
// by sign or zero and keeps 2W product bits, which fit the true product
// in either mode. Purely combinational.
module mia_mult #(
    parameter int W = 32
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           signed_mode,
    output logic [2*W-1:0] prod
);
    logic [2*W-1:0] a_ext;
    logic [2*W-1:0] b_ext;

    // Extend operands according to the signedness mode, then multiply.
    always_comb begin
        a_ext = {{W{signed_mode & a[W-1]}}, a};
        b_ext = {{W{signed_mode & b[W-1]}}, b};
        prod  = a_ext * b_ext;
    end
endmodule

// File: rtl/mia_arith_unit.sv
// Module: integer arithmetic execute unit. It combines the shared adder,
// the compares, the leading-bit counter and the multiplier, and selects
// the outputs by operation code. Assumes immediates arrive sign-extended
// on opb. A checked overflow drops the register write instead of
// trapping. Purely combinational: the pipeline registers around it hold
// state.
module mia_arith_unit
    import mia_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic [OP_W-1:0]   op_sel,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [ADDR_W-1:0] dst_in,
    input  logic              wb_req,
    output logic              wb_en,
    output logic [ADDR_W-1:0] dst_out,
    output logic [DATA_W-1:0] result,
    output logic [DATA_W-1:0] hi_val,
    output logic [DATA_W-1:0] lo_val,
    output logic              hi_we,
    output logic              lo_we
);
    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam int PROD_W = 2 * DATA_W;

    logic              is_sub;
    logic [DATA_W-1:0] as_sum;
    logic              as_ovf;
    logic [CNT_W-1:0]  lead_cnt;
    logic [PROD_W-1:0] prod;
    logic              lt_s;
    logic              lt_u;

    // Subtract-type codes route through the adder in subtract mode.
    always_comb is_sub = (op_sel == OPC_SUB) || (op_sel == OPC_SUBU);

    mia_addsub #(.W(DATA_W)) u_addsub (
        .a   (opa),
        .b   (opb),
        .sub (is_sub),
        .sum (as_sum),
        .ovf (as_ovf)
    );

    mia_lead_count #(.W(DATA_W), .CW(CNT_W)) u_lead (
        .val        (opa),
        .count_ones (op_sel == OPC_CLO),
        .count      (lead_cnt)
    );

    mia_mult #(.W(DATA_W)) u_mult (
        .a           (opa),
        .b           (opb),
        .signed_mode (op_sel != OPC_MULTU),
        .prod        (prod)
    );

    // Signed and unsigned less-than for the compare codes.
    always_comb begin
        lt_s = $signed(opa) < $signed(opb);
        lt_u = opa < opb;
    end

    // Output selection by operation code.
    always_comb begin
        wb_en   = wb_req;
        dst_out = dst_in;
        result  = '0;
        hi_val  = '0;
        lo_val  = '0;
        hi_we   = 1'b0;
        lo_we   = 1'b0;
        case (op_sel)
            OPC_ADD, OPC_SUB, OPC_ADDI: begin
                result = as_sum;
                wb_en  = wb_req & ~as_ovf;
            end
            OPC_ADDU, OPC_SUBU, OPC_ADDIU: result = as_sum;
            OPC_SLT, OPC_SLTI:             result = DATA_W'(lt_s);
            OPC_SLTU, OPC_SLTIU:           result = DATA_W'(lt_u);
            OPC_CLZ, OPC_CLO:              result = DATA_W'(lead_cnt);
            OPC_MUL:                       result = prod[DATA_W-1:0];
            OPC_MULT, OPC_MULTU: begin
                wb_en  = 1'b0;
                hi_val = prod[PROD_W-1:DATA_W];
                lo_val = prod[DATA_W-1:0];
                hi_we  = 1'b1;
                lo_we  = 1'b1;
            end
            default: begin
                wb_en   = 1'b0;
                dst_out = '0;
            end
        endcase
    end
endmodule

// File: rtl/mia_arith_checker.sv
// Checker: immediate properties on the settled ports of the arithmetic
// unit. Assumes the inputs are stable while the comb logic is evaluated.
module mia_arith_checker
    import mia_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input logic [OP_W-1:0]   op_sel,
    input logic [DATA_W-1:0] opa,
    input logic [DATA_W-1:0] opb,
    input logic [ADDR_W-1:0] dst_in,
    input logic              wb_req,
    input logic              wb_en,
    input logic [ADDR_W-1:0] dst_out,
    input logic [DATA_W-1:0] result,
    input logic [DATA_W-1:0] hi_val,
    input logic [DATA_W-1:0] lo_val,
    input logic              hi_we,
    input logic              lo_we
);
    localparam int MSB = DATA_W - 1;

    logic is_add_chk;
    logic is_unsigned_as;
    logic is_cmp;
    logic is_hilo;
    logic is_known;

    // Group the operation codes for the properties below.
    always_comb begin
        is_add_chk     = (op_sel == OPC_ADD) || (op_sel == OPC_ADDI);
        is_unsigned_as = (op_sel == OPC_ADDU) || (op_sel == OPC_SUBU) || (op_sel == OPC_ADDIU);
        is_cmp         = (op_sel == OPC_SLT) || (op_sel == OPC_SLTU)
                       || (op_sel == OPC_SLTI) || (op_sel == OPC_SLTIU);
        is_hilo        = (op_sel == OPC_MULT) || (op_sel == OPC_MULTU);
        is_known       = (op_sel != OPC_NONE) && (op_sel <= OPC_SLTIU);
    end

    // Property checks on the settled outputs.
    always_comb begin
        if (is_add_chk)
            p_add_sum_r1: assert (result == opa + opb);
        if (is_add_chk && (opa[MSB] == opb[MSB]) && (result[MSB] != opa[MSB]))
            p_no_overflow_r2: assert (!wb_en);
        if (is_unsigned_as)
            p_unsigned_keep_r3: assert (wb_en == wb_req);
        if (is_cmp)
            p_cmp_bool_r4: assert (result[DATA_W-1:1] == '0);
        if ((op_sel == OPC_CLZ) && (opa == '0))
            p_clz_full_r5: assert (result == DATA_W'(DATA_W));
        if ((op_sel == OPC_CLO) && (opa == '1))
            p_clo_full_r6: assert (result == DATA_W'(DATA_W));
        if (is_hilo)
            p_hilo_write_r8: assert (hi_we && lo_we && !wb_en && result == '0);
        if (!is_hilo)
            p_hilo_quiet_r10: assert (!hi_we && !lo_we && hi_val == '0 && lo_val == '0);
        if (is_known)
            p_dst_pass_r10: assert (dst_out == dst_in);
        if (!is_known)
            p_idle_r11: assert (!wb_en && dst_out == '0 && result == '0);
        if (!wb_req)
            p_gated_r12: assert (!wb_en);
    end
endmodule

bind mia_arith_unit mia_arith_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .op_sel  (op_sel),
    .opa     (opa),
    .opb     (opb),
    .dst_in  (dst_in),
    .wb_req  (wb_req),
    .wb_en   (wb_en),
    .dst_out (dst_out),
    .result  (result),
    .hi_val  (hi_val),
    .lo_val  (lo_val),
    .hi_we   (hi_we),
    .lo_we   (lo_we)
);

// File: tb/mia_arith_unit_tb.sv
// Bench: directed corners plus seeded random vectors, compared against
// expected values that are derived from the requirements.
module mia_arith_unit_tb;
    import mia_pkg::*;

    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    op_sel = '0;
    logic [W-1:0]  opa = '0, opb = '0;
    logic [4:0]    dst_in = '0;
    logic          wb_req = 1'b0;
    logic          wb_en, hi_we, lo_we;
    logic [4:0]    dst_out;
    logic [W-1:0]  result, hi_val, lo_val;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic         e_wb, e_hwe, e_lwe;
    logic [4:0]   e_dst;
    logic [W-1:0] e_res, e_hi, e_lo;
    string        e_tag;

    always #5 clk = ~clk;

    mia_arith_unit u_dut (
        .op_sel(op_sel), .opa(opa), .opb(opb), .dst_in(dst_in), .wb_req(wb_req),
        .wb_en(wb_en), .dst_out(dst_out), .result(result), .hi_val(hi_val),
        .lo_val(lo_val), .hi_we(hi_we), .lo_we(lo_we)
    );

    // Count leading bits equal to pol, scanning down from bit 31.
    function automatic logic [W-1:0] lead_run(input logic [W-1:0] v, input logic pol);
        int n = 0;
        for (int i = W - 1; i >= 0; i--) begin
            if (v[i] != pol) break;
            n++;
        end
        return W'(n);
    endfunction

    // Expected outputs from the requirements.
    task automatic expect_for(input logic [4:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                              input logic [4:0] d, input logic req);
        longint s;
        logic [63:0] p;
        e_wb = req; e_dst = d; e_res = '0; e_hi = '0; e_lo = '0; e_hwe = 0; e_lwe = 0;
        case (op)
            OPC_ADD, OPC_ADDI: begin
                s = longint'($signed(a)) + longint'($signed(b));
                e_res = a + b; e_tag = "R1/R2";
                if (s > 64'sd2147483647 || s < -64'sd2147483648) e_wb = 0;
            end
            OPC_SUB: begin
                s = longint'($signed(a)) - longint'($signed(b));
                e_res = a - b; e_tag = "R1/R2";
                if (s > 64'sd2147483647 || s < -64'sd2147483648) e_wb = 0;
            end
            OPC_ADDU, OPC_ADDIU: begin e_res = a + b; e_tag = "R3"; end
            OPC_SUBU: begin e_res = a - b; e_tag = "R3"; end
            OPC_SLT, OPC_SLTI: begin
                e_res = (longint'($signed(a)) < longint'($signed(b))) ? 1 : 0; e_tag = "R4";
            end
            OPC_SLTU, OPC_SLTIU: begin
                e_res = ({32'b0, a} < {32'b0, b}) ? 1 : 0; e_tag = "R4";
            end
            OPC_CLZ: begin e_res = lead_run(a, 1'b0); e_tag = "R5"; end
            OPC_CLO: begin e_res = lead_run(a, 1'b1); e_tag = "R6"; end
            OPC_MUL: begin p = {32'b0, a} * {32'b0, b}; e_res = p[31:0]; e_tag = "R7"; end
            OPC_MULT: begin
                s = longint'($signed(a)) * longint'($signed(b)); p = s;
                e_hi = p[63:32]; e_lo = p[31:0]; e_hwe = 1; e_lwe = 1; e_wb = 0; e_tag = "R8";
            end
            OPC_MULTU: begin
                p = {32'b0, a} * {32'b0, b};
                e_hi = p[63:32]; e_lo = p[31:0]; e_hwe = 1; e_lwe = 1; e_wb = 0; e_tag = "R9";
            end
            default: begin e_wb = 0; e_dst = '0; e_tag = "R11"; end
        endcase
        if (!req) e_tag = {e_tag, "/R12"};
    endtask

    // Compare every output with the expectation (the R10 fields included).
    task automatic compare(input string note);
        checks++;
        if (wb_en !== e_wb || dst_out !== e_dst || result !== e_res || hi_val !== e_hi
            || lo_val !== e_lo || hi_we !== e_hwe || lo_we !== e_lwe) begin
            errors++;
            $display("FAIL %s/R10 %s op=%0d a=%h b=%h: got wb=%b dst=%0d res=%h hi=%h lo=%h we=%b%b exp wb=%b dst=%0d res=%h hi=%h lo=%h we=%b%b",
                     e_tag, note, op_sel, opa, opb, wb_en, dst_out, result, hi_val, lo_val,
                     hi_we, lo_we, e_wb, e_dst, e_res, e_hi, e_lo, e_hwe, e_lwe);
        end
    endtask

    // Drive after a rising edge, check on the next falling edge.
    task automatic run(input logic [4:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [4:0] d, input logic req, input string note);
        @(posedge clk); #1;
        op_sel = op; opa = a; opb = b; dst_in = d; wb_req = req;
        expect_for(op, a, b, d, req);
        @(negedge clk);
        compare(note);
    endtask

    // Biased operand draw.
    function automatic logic [W-1:0] pick_operand();
        logic [W-1:0] r = $urandom;
        case ($urandom % 6)
            0: return r;
            1: return r % 16;
            2: return 32'h8000_0000 + (r % 8) - 4;
            3: return 32'hFFFF_FFFF - (r % 8);
            4: return r >> ($urandom % 33);
            default: return ~(r >> ($urandom % 33));
        endcase
    endfunction

    initial begin
        logic [4:0] op;
        logic [W-1:0] a, b;
        logic [15:0] imm;
        int seed_init;
        seed_init = $urandom(32'd20240611);
        // Reset phase: idle inputs give all-zero outputs (R11).
        repeat (3) @(posedge clk);
        expect_for(OPC_NONE, '0, '0, '0, 1'b0);
        @(negedge clk);
        compare("reset idle R11");
        rst_n = 1'b1;

        run(OPC_ADD,   32'h8000_0001, 32'h8000_0002, 5'd3, 1, "ADD overflow R2");
        run(OPC_ADDU,  32'h8000_0001, 32'h8000_0002, 5'd4, 1, "ADDU wrap R3");
        run(OPC_ADD,   32'h7FFF_FFFF, 32'h0000_0001, 5'd5, 1, "ADD +ovf R2");
        run(OPC_SUB,   32'h8000_0000, 32'h0000_0001, 5'd6, 1, "SUB min-1 R2");
        run(OPC_SUB,   32'h0000_0000, 32'h8000_0000, 5'd7, 1, "SUB 0-min R2");
        run(OPC_SUB,   32'hFFFF_FFFF, 32'h8000_0000, 5'd8, 1, "SUB -1-min no ovf R2");
        run(OPC_SUBU,  32'h8000_0001, 32'h0000_0003, 5'd5, 1, "SUBU R3");
        run(OPC_ADDI,  32'h7FFF_FFF0, 32'h0000_0010, 5'd9, 1, "ADDI ovf R2");
        run(OPC_ADDIU, 32'h0000_0005, 32'hFFFF_FFFF, 5'd9, 1, "ADDIU R1");
        run(OPC_SLT,   32'hFFFF_FFFF, 32'h0000_0001, 5'd1, 1, "SLT signed R4");
        run(OPC_SLTU,  32'hFFFF_FFFF, 32'h0000_0001, 5'd1, 1, "SLTU unsigned R4");
        run(OPC_SLTI,  32'h0000_0002, 32'h0000_0002, 5'd1, 1, "SLTI equal R4");
        run(OPC_CLZ,   32'h0000_0000, 32'h0,         5'd2, 1, "CLZ zero R5");
        run(OPC_CLZ,   32'h0000_0001, 32'h0,         5'd2, 1, "CLZ one R5");
        run(OPC_CLZ,   32'h8000_0000, 32'h0,         5'd2, 1, "CLZ msb R5");
        run(OPC_CLO,   32'hFFFF_FFFF, 32'h0,         5'd2, 1, "CLO ones R6");
        run(OPC_CLO,   32'h7FFF_FFFF, 32'h0,         5'd2, 1, "CLO none R6");
        run(OPC_CLO,   32'hFFF0_0000, 32'h0,         5'd2, 1, "CLO twelve R6");
        run(OPC_MUL,   32'hFFFF_FFFF, 32'h0000_0003, 5'd10, 1, "MUL low R7");
        run(OPC_MULT,  32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd11, 1, "MULT -1*-1 R8");
        run(OPC_MULT,  32'h8000_0000, 32'h0000_0002, 5'd11, 1, "MULT min*2 R8");
        run(OPC_MULTU, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd12, 1, "MULTU max R9");
        run(5'd20,     32'h1234_5678, 32'h1,         5'd13, 1, "unrecognised R11");
        run(OPC_NONE,  32'h1234_5678, 32'h1,         5'd13, 1, "none R11");
        run(OPC_ADDU,  32'h1,         32'h1,         5'd14, 0, "no request R12");

        for (int k = 0; k < 3000; k++) begin
            op = ($urandom % 8 == 0) ? 5'(16 + $urandom % 16) : 5'($urandom % 16);
            a = pick_operand();
            b = pick_operand();
            if (op >= OPC_ADDI && op <= OPC_SLTIU) begin
                imm = 16'($urandom);
                b = {{16{imm[15]}}, imm};
            end
            run(op, a, b, 5'($urandom), ($urandom % 5) != 0, "random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(10 * 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule